// File: doc/BRIEF.md
# Dual-Mode Programmable Frequency Divider

This block divides a local-oscillator signal by a programmed ratio N and gives one output pulse every N input cycles, for use by a phase comparator. Each of the two oscillator inputs arrives as a one-clock enable: a high-band input and a low-band input. All logic runs on a single system clock. Two mode bits pick the source and the division method. The high-band source, and the low-band source in its upper range, use pulse-swallow division. That method has a 16/17 dual-modulus prescaler, a 4-bit swallow counter and a 12-bit main counter. The low-band source in its lower range drives the 12-bit counter directly.

A 16-bit divisor word is read in one of two ways. In pulse-swallow mode the whole word is N. The low nibble A sets how many prescaler cycles divide by 17, and the upper twelve bits M set the number of prescaler cycles, so N = 16·M + A. In direct mode the low nibble is ignored and N is the upper twelve bits. The source, the mode and N are captured on the first input event of each output period. Later changes wait for the next terminal count, so a period already running is never shortened. An inhibit input halts division and restarts the count.

Top module: `fdiv_top`

## Requirements
- R1: While reset is held and until the first full period has been counted, div_pulse_o stays 0.
- R2: When src_hi_i is 1, only hi_evt_i events are counted, in pulse-swallow mode, with N equal to div_word_i (whatever rng_wide_i is).
- R3: When src_hi_i is 0 and rng_wide_i is 1, lo_evt_i events are counted in pulse-swallow mode with N equal to div_word_i.
- R4: When src_hi_i and rng_wide_i are both 0, lo_evt_i events are counted in direct mode with N = div_word_i[15:4]; bits [3:0] have no effect.
- R5: In pulse-swallow mode, a period is made of A prescaler cycles of 17 events followed by M−A cycles of 16 events, where A = div_word_i[3:0] and M = div_word_i[15:4], for a total of 16·M + A events; the swallow count is used up when the main counter ends the period.
- R6: In pulse-swallow mode a word below 272 divides by 272.
- R7: In direct mode an upper-field value below 4 divides by 4.
- R8: The source, the mode and N are taken from the inputs present at the first counted event of a period; changes made later in that period apply from the next period.
- R9: While inhibit_i is 1 no pulse is produced and no event is counted; counting restarts from zero once inhibit_i returns to 0.
- R10: div_pulse_o is high for exactly one clock: the clock that follows the clock edge at which the Nth event of the period is sampled.
- R11: Events on the input that is not selected have no effect on the count or on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_evt_i | input | 1 | High-band oscillator event, one clock per input cycle |
| lo_evt_i | input | 1 | Low-band oscillator event, one clock per input cycle |
| src_hi_i | input | 1 | Source select: 1 = high band (swallow), 0 = low band |
| rng_wide_i | input | 1 | Low-band range: 1 = swallow mode, 0 = direct mode |
| div_word_i | input | 16 | Divisor word, read according to the mode |
| inhibit_i | input | 1 | Halts division and clears the period count |
| div_pulse_o | output | 1 | One-clock pulse per N counted events |

## Verification
A wrong prescaler modulus or a wrong swallow count does not stop the output. It moves the pulse by one or more events in every period, so the first terminal count after the fault shows it. A source or mode that is latched at the wrong moment shows up as a wrong period at the boundary where a changed word or source should first apply. A count that is not cleared by inhibit shows up as a shortened first period after release. The bench follows every clock with an independent period model, so a shift of a single cycle in any pulse is caught in the period where it occurs.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  typedef enum logic {
    MODE_SWALLOW = 1'b0,
    MODE_DIRECT  = 1'b1
  } div_mode_e;

  // Direct division only for the low band in its lower range.
  function automatic div_mode_e pick_mode(input logic src_hi, input logic rng_wide);
    return (!src_hi && !rng_wide) ? MODE_DIRECT : MODE_SWALLOW;
  endfunction

endpackage

// File: rtl/fdiv_cfg.sv
module fdiv_cfg
  import fdiv_pkg::*;
#(
  parameter int SWL_W   = 4,
  parameter int MAIN_W  = 12,
  parameter int DIR_MIN = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hi_evt,
  input  logic                    lo_evt,
  input  logic                    src_hi,
  input  logic                    rng_wide,
  input  logic [SWL_W+MAIN_W-1:0] div_word,
  input  logic                    armed,
  input  logic                    start,
  output div_mode_e               mode,
  output logic [MAIN_W-1:0]       m_eff,
  output logic [SWL_W-1:0]        a_eff,
  output logic                    evt
);
  localparam int WORD_W   = SWL_W + MAIN_W;
  localparam int SW_MIN_M = (1 << SWL_W) + 1;

  function automatic logic [MAIN_W-1:0] clamp_m(input div_mode_e md,
                                                 input logic [MAIN_W-1:0] m);
    logic [MAIN_W-1:0] lim;
    lim = (md == MODE_DIRECT) ? MAIN_W'(DIR_MIN) : MAIN_W'(SW_MIN_M);
    return (m < lim) ? lim : m;
  endfunction

  function automatic logic [SWL_W-1:0] clamp_a(input div_mode_e md,
                                                input logic [MAIN_W-1:0] m,
                                                input logic [SWL_W-1:0] a);
    if (md == MODE_DIRECT) return '0;
    return (m < MAIN_W'(SW_MIN_M)) ? '0 : a;
  endfunction

  div_mode_e         live_mode, lat_mode;
  logic [MAIN_W-1:0] live_m, lat_m;
  logic [SWL_W-1:0]  live_a, lat_a;
  logic              lat_high, sel_high;

  assign live_mode = pick_mode(src_hi, rng_wide);
  assign live_m    = clamp_m(live_mode, div_word[WORD_W-1:SWL_W]);
  assign live_a    = clamp_a(live_mode, div_word[WORD_W-1:SWL_W], div_word[SWL_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_mode <= MODE_SWALLOW;
      lat_m    <= '0;
      lat_a    <= '0;
      lat_high <= 1'b0;
    end else if (start) begin
      lat_mode <= live_mode;
      lat_m    <= live_m;
      lat_a    <= live_a;
      lat_high <= src_hi;
    end
  end

  assign mode     = armed ? lat_mode : live_mode;
  assign m_eff    = armed ? lat_m    : live_m;
  assign a_eff    = armed ? lat_a    : live_a;
  assign sel_high = armed ? lat_high : src_hi;
  assign evt      = sel_high ? hi_evt : lo_evt;

endmodule

// File: rtl/fdiv_prescaler.sv
module fdiv_prescaler #(
  parameter int SWL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             start,
  input  logic             armed,
  input  logic [SWL_W-1:0] a_eff,
  output logic             pre_tc,
  output logic             swl_zero
);
  localparam int PRE_W = SWL_W + 1;
  localparam logic [PRE_W-1:0] LAST_LONG  = PRE_W'(1 << SWL_W);
  localparam logic [PRE_W-1:0] LAST_SHORT = PRE_W'((1 << SWL_W) - 1);

  logic [PRE_W-1:0] pre_q, pre_eff, last;
  logic [SWL_W-1:0] swl_q, swl_eff;

  assign pre_eff  = armed ? pre_q : '0;
  assign swl_eff  = armed ? swl_q : a_eff;
  assign swl_zero = (swl_eff == '0);
  assign last     = swl_zero ? LAST_SHORT : LAST_LONG;
  assign pre_tc   = step && (pre_eff == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      swl_q <= '0;
    end else if (step) begin
      pre_q <= pre_tc ? '0 : pre_eff + 1'b1;
      swl_q <= (pre_tc && !swl_zero) ? swl_eff - 1'b1 : swl_eff;
    end else if (start) begin
      pre_q <= '0;
      swl_q <= a_eff;
    end
  end

endmodule

// File: rtl/fdiv_main_cnt.sv
module fdiv_main_cnt #(
  parameter int MAIN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              start,
  input  logic              armed,
  input  logic [MAIN_W-1:0] m_eff,
  output logic              term
);
  logic [MAIN_W-1:0] cnt_q, cnt_eff;

  assign cnt_eff = armed ? cnt_q : '0;
  assign term    = step && (cnt_eff == m_eff - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (step)   cnt_q <= cnt_eff + 1'b1;
    else if (start)  cnt_q <= '0;
  end

endmodule

// File: rtl/fdiv_top.sv
module fdiv_top
  import fdiv_pkg::*;
#(
  parameter int SWL_W   = 4,
  parameter int MAIN_W  = 12,
  parameter int DIR_MIN = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hi_evt_i,
  input  logic                    lo_evt_i,
  input  logic                    src_hi_i,
  input  logic                    rng_wide_i,
  input  logic [SWL_W+MAIN_W-1:0] div_word_i,
  input  logic                    inhibit_i,
  output logic                    div_pulse_o
);
  div_mode_e         mode;
  logic [MAIN_W-1:0] m_eff;
  logic [SWL_W-1:0]  a_eff;
  logic              evt, evt_ok, start, armed, mode_direct;
  logic              pre_tc, swl_zero, main_step, main_term;

  assign evt_ok      = evt && !inhibit_i;
  assign start       = evt_ok && !armed;
  assign mode_direct = (mode == MODE_DIRECT);
  assign main_step   = mode_direct ? evt_ok : pre_tc;

  fdiv_cfg #(.SWL_W(SWL_W), .MAIN_W(MAIN_W), .DIR_MIN(DIR_MIN)) cfg_i (
    .clk(clk), .rst_n(rst_n), .hi_evt(hi_evt_i), .lo_evt(lo_evt_i),
    .src_hi(src_hi_i), .rng_wide(rng_wide_i), .div_word(div_word_i),
    .armed(armed), .start(start), .mode(mode), .m_eff(m_eff),
    .a_eff(a_eff), .evt(evt)
  );

  fdiv_prescaler #(.SWL_W(SWL_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .step(evt_ok && !mode_direct),
    .start(start && !mode_direct), .armed(armed), .a_eff(a_eff),
    .pre_tc(pre_tc), .swl_zero(swl_zero)
  );

  fdiv_main_cnt #(.MAIN_W(MAIN_W)) main_i (
    .clk(clk), .rst_n(rst_n), .step(main_step), .start(start),
    .armed(armed), .m_eff(m_eff), .term(main_term)
  );

  // armed: a period is in progress and its settings are latched
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      div_pulse_o <= 1'b0;
    end else begin
      div_pulse_o <= main_term;
      if (inhibit_i)   armed <= 1'b0;
      else if (evt_ok) armed <= !main_term;
    end
  end

endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker #(
  parameter int SWL_W   = 4,
  parameter int MAIN_W  = 12,
  parameter int DIR_MIN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inhibit,
  input logic              evt_ok,
  input logic              main_term,
  input logic              swl_zero,
  input logic              mode_direct,
  input logic [MAIN_W-1:0] m_eff,
  input logic [SWL_W-1:0]  a_eff,
  input logic              div_pulse
);
  localparam int CW = SWL_W + MAIN_W + 1;

  logic [CW-1:0] per_cnt, n_exp;

  always_ff @(posedge clk) begin
    if (!rst_n || inhibit) per_cnt <= '0;
    else if (evt_ok)       per_cnt <= main_term ? '0 : per_cnt + 1'b1;
  end

  assign n_exp = mode_direct ? CW'(m_eff) : ((CW'(m_eff) << SWL_W) + CW'(a_eff));

  p_period_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    main_term |-> ((per_cnt + 1'b1) == n_exp));

  p_swallow_spent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (main_term && !mode_direct) |-> swl_zero);

  p_min_swallow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_direct |-> (m_eff >= MAIN_W'((1 << SWL_W) + 1)));

  p_min_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_direct |-> (m_eff >= MAIN_W'(DIR_MIN)));

  p_inhibit_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> !div_pulse);

  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

endmodule

bind fdiv_top fdiv_checker #(.SWL_W(SWL_W), .MAIN_W(MAIN_W), .DIR_MIN(DIR_MIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .inhibit(inhibit_i), .evt_ok(evt_ok),
  .main_term(main_term), .swl_zero(swl_zero), .mode_direct(mode_direct),
  .m_eff(m_eff), .a_eff(a_eff), .div_pulse(div_pulse_o)
);

// File: tb/fdiv_top_tb_top.sv
`timescale 1ns/1ps
module fdiv_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi_evt = 1'b0, lo_evt = 1'b0, src_hi = 1'b1, rng_wide = 1'b0, inhibit = 1'b0;
  logic [15:0] word = 16'd272;
  logic div_pulse;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fdiv_top dut_i (
    .clk(clk), .rst_n(rst_n), .hi_evt_i(hi_evt), .lo_evt_i(lo_evt),
    .src_hi_i(src_hi), .rng_wide_i(rng_wide), .div_word_i(word),
    .inhibit_i(inhibit), .div_pulse_o(div_pulse)
  );

  // Ratio restated from the requirements: whole word, or upper field.
  function automatic int ratio(bit s, bit r, logic [15:0] w);
    int m;
    if (s || r) return (w < 16'd272) ? 272 : int'(w);
    m = int'(w) / 16;
    return (m < 4) ? 4 : m;
  endfunction

  // Reference period model
  int  cnt = 0, per_n = 0;
  bit  per_hi = 0, exp_pulse = 0;
  always @(posedge clk) begin
    bit use_hi, ev;
    if (!rst_n || inhibit) begin
      cnt = 0; exp_pulse = 0;
    end else begin
      use_hi = (cnt == 0) ? src_hi : per_hi;
      ev = use_hi ? hi_evt : lo_evt;
      exp_pulse = 0;
      if (ev) begin
        if (cnt == 0) begin
          per_hi = src_hi;
          per_n  = ratio(src_hi, rng_wide, word);
        end
        cnt++;
        if (cnt == per_n) begin
          exp_pulse = 1; cnt = 0;
        end
      end
    end
  end

  task automatic check(string tag);
    tests++;
    if (div_pulse !== exp_pulse) begin
      fails++;
      $display("FAIL %s: div_pulse=%0b expected %0b at %0t", tag, div_pulse, exp_pulse, $time);
    end
  endtask

  // One clock per iteration: check result of previous edge, then drive.
  task automatic run(string tag, int cycles, int hi_pct, int lo_pct,
                     int chg_pct, int inh_pct, bit s, bit r, logic [15:0] w);
    src_hi = s; rng_wide = r; word = w;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(tag);
      hi_evt  = ($urandom % 100) < hi_pct;
      lo_evt  = ($urandom % 100) < lo_pct;
      inhibit = ($urandom % 100) < inh_pct;
      if (($urandom % 1000) < chg_pct) word = w + 16'($urandom % 64);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: held reset keeps output low
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      tests++;
      if (div_pulse !== 1'b0) begin
        fails++;
        $display("FAIL R1: div_pulse=%0b expected 0 in reset", div_pulse);
      end
    end
    rst_n = 1'b1;
    // R1, R5, R10: dense high-band events, A=15 M=17 -> 287
    run("R1/R5/R10", 1200, 100, 0, 0, 0, 1'b1, 1'b0, 16'h011F);
    // R5: A=0 and mid values
    run("R5", 1500, 100, 50, 0, 0, 1'b1, 1'b1, 16'h0130);
    run("R5", 2000, 80, 0, 0, 0, 1'b1, 1'b0, 16'h0A37);
    // R2: high band random words, range bit either way
    for (int k = 0; k < 6; k++)
      run("R2", 3000, 60, 60, 0, 0, 1'b1, 1'($urandom % 2),
          16'(272 + $urandom % 900));
    // R3: low band swallow
    for (int k = 0; k < 6; k++)
      run("R3", 3000, 60, 60, 0, 0, 1'b0, 1'b1, 16'(272 + $urandom % 900));
    // R4: direct, random low nibble ignored
    for (int k = 0; k < 6; k++)
      run("R4", 2000, 60, 70, 0, 0, 1'b0, 1'b0, 16'(64 + $urandom % 4000));
    run("R4", 800, 0, 100, 0, 0, 1'b0, 1'b0, 16'h00AF);
    // R6: swallow clamp
    run("R6", 1500, 100, 0, 0, 0, 1'b1, 1'b0, 16'd5);
    run("R6", 1500, 0, 90, 0, 0, 1'b0, 1'b1, 16'd271);
    // R7: direct clamp
    run("R7", 200, 0, 100, 0, 0, 1'b0, 1'b0, 16'h0012);
    run("R7", 200, 0, 70, 0, 0, 1'b0, 1'b0, 16'h0000);
    run("R7", 200, 0, 100, 0, 0, 1'b0, 1'b0, 16'h005F);
    // R8: words change inside periods; source and mode flip between runs
    for (int k = 0; k < 8; k++)
      run("R8", 2500, 70, 70, 8, 0, 1'($urandom % 2), 1'($urandom % 2),
          16'(16 + $urandom % 1000));
    // R9: random inhibit
    for (int k = 0; k < 4; k++)
      run("R9", 3000, 80, 80, 0, 3, 1'($urandom % 2), 1'($urandom % 2),
          16'(272 + $urandom % 300));
    run("R9", 400, 100, 100, 0, 100, 1'b0, 1'b0, 16'h0040);
    // R11: only the unselected input is active
    run("R11", 1000, 0, 100, 0, 0, 1'b1, 1'b1, 16'd272);
    run("R11", 600, 100, 0, 0, 0, 1'b0, 1'b0, 16'h0040);
    run("R11", 1000, 0, 100, 0, 0, 1'b1, 1'b0, 16'd300);
    @(negedge clk);
    check("R10");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule